// File: doc/BRIEF.md
# Controller-Side Serial Byte Engine

This block is the byte-level engine of a single-lane serial bus controller. A sequencer above it issues simple commands: select the target, shift a byte out, run a turnaround of a chosen length, shift a byte in, clear or read the receive CRC, and release the select. The engine makes the serial clock from the fabric clock and controls the direction of the shared data line. It knows nothing about packets or channels. Every outbound byte, including any CRC byte, is shifted out exactly as the sequencer supplies it.

The length of each turnaround comes from its command. A test sequence can therefore drive a turnaround that is too short or too long on purpose, and the engine carries it out clock for clock. Inbound bytes feed an 8-bit CRC register. Once a packet's trailing check byte has arrived, the sequencer reads that register: zero means the packet arrived intact.

Top module: `sbus_byte_engine`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `io_oe` is 0, `io_out` is 0, `cmd_ready` is 1, `done` is 0, `crc_out` is 0x00 and the receive CRC holds 0x00.
- R2: Opcode 0 pulls `cs_n` low and opcode 6 drives it high, in the cycle after acceptance. Opcode 6 also releases `io_oe` and zeroes `io_out`. No other command changes `cs_n`.
- R3: Each serial clock period lasts DIV fabric cycles (default 5). `sck` is low for the first DIV-DIV/2 cycles and high for the last DIV/2. `sck` stays low whenever no send, turnaround or receive is running.
- R4: Opcode 1 shifts `cmd_arg` out MSB first over exactly 8 serial clocks, with `io_oe` high. The first bit appears in the cycle after acceptance, and each later bit changes where `sck` falls. After the byte, the last bit and `io_oe` stay as they are. No extra byte is ever appended.
- R5: Opcode 2 runs exactly `cmd_arg` serial clocks (1, 2 and 3 are all honoured) with `io_oe` low and `io_out` 0 from the cycle after acceptance. A count of 0 completes with no clock.
- R6: Opcode 3 samples `io_in` at each rising `sck` over 8 clocks, MSB first, with `io_oe` low. The assembled byte appears on `rx_data` in the cycle `done` is high.
- R7: Each received byte updates the receive CRC, which uses polynomial 0x07 with no reflection and no final XOR. After a byte stream followed by its own CRC byte, the residue is 0x00.
- R8: Opcode 4 clears the receive CRC to 0x00. Sent bytes and turnaround clocks leave it unchanged.
- R9: Opcode 5 copies the receive CRC to `crc_out`, which is valid in the cycle `done` is high. A read accepted in the `done` cycle of a receive returns the value that already includes that byte.
- R10: A command is accepted when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while a send, turnaround or receive is in progress and high otherwise. `done` is a one-cycle pulse: it comes in the cycle after acceptance for opcodes 0, 4, 5, 6, 7 (7 is a no-op) and for a zero-length turnaround. For the other commands it comes in the cycle after their last serial clock ends, with `sck` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_op | input | 3 | Command opcode |
| cmd_arg | input | W | Byte to send, or turnaround clock count |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | W | Last received byte |
| crc_out | output | W | Receive CRC as last read |
| cs_n | output | 1 | Active-low target select |
| sck | output | 1 | Serial clock |
| io_out | output | 1 | Data line output value |
| io_oe | output | 1 | Data line output enable |
| io_in | input | 1 | Data line input |

## Verification
The delicate case is a command's `done` cycle coinciding with acceptance of the next command. Two instances matter most. A CRC read can be accepted in the very cycle a receive completes, and it must see the CRC update made at that same edge. A select release can be accepted in the cycle a send completes, and it must drop `io_oe` without shortening the final bit. The bench issues every command back to back, with no idle cycles, so these overlaps happen throughout the run. A behavioural model predicts the pins cycle by cycle, and the bench compares them against it. A received stream followed by its computed CRC byte must read back a residue of zero when the read falls in the receive's done cycle.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
   typedef enum logic [2:0] {
      OP_SEL_ON  = 3'd0,
      OP_SEND    = 3'd1,
      OP_TURN    = 3'd2,
      OP_RECV    = 3'd3,
      OP_CRC_CLR = 3'd4,
      OP_CRC_RD  = 3'd5,
      OP_SEL_OFF = 3'd6,
      OP_NOP     = 3'd7
   } sbe_op_e;
endpackage

// File: rtl/sbe_clkdiv.sv
module sbe_clkdiv #(
   parameter int DIV = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sck,
   output logic rise_tick,
   output logic slot_end
);
   localparam int HIGH_T = DIV / 2;
   localparam int LOW_T  = DIV - HIGH_T;
   localparam int PH_W   = (DIV > 2) ? $clog2(DIV) : 1;

   logic [PH_W-1:0] ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= '0;
      end else if (!run || ph == PH_W'(DIV - 1)) begin
         ph <= '0;
      end else begin
         ph <= ph + 1'b1;
      end
   end

   assign sck       = run && (ph >= PH_W'(LOW_T));
   assign rise_tick = run && (ph == PH_W'(LOW_T - 1));
   assign slot_end  = run && (ph == PH_W'(DIV - 1));
endmodule

// File: rtl/sbe_rx_crc.sv
module sbe_rx_crc #(
   parameter int         W    = 8,
   parameter logic [W-1:0] POLY = 8'h07
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         upd,
   input  logic [W-1:0] din,
   output logic [W-1:0] residue
);
   logic [W-1:0] stg [0:W];

   assign stg[0] = residue ^ din;

   for (genvar i = 0; i < W; i++) begin : g_stage
      assign stg[i+1] = stg[i][W-1] ? ((stg[i] << 1) ^ POLY) : (stg[i] << 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         residue <= '0;
      end else if (clr) begin
         residue <= '0;
      end else if (upd) begin
         residue <= stg[W];
      end
   end
endmodule

// File: rtl/sbus_byte_engine.sv
module sbus_byte_engine
   import sbe_pkg::*;
#(
   parameter int           DIV      = 5,
   parameter int           W        = 8,
   parameter logic [W-1:0] CRC_POLY = 8'h07
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmd_valid,
   output logic         cmd_ready,
   input  logic [2:0]   cmd_op,
   input  logic [W-1:0] cmd_arg,
   output logic         done,
   output logic [W-1:0] rx_data,
   output logic [W-1:0] crc_out,
   output logic         cs_n,
   output logic         sck,
   output logic         io_out,
   output logic         io_oe,
   input  logic         io_in
);
   localparam int CNT_W = W;

   if (DIV < 2) begin : g_div_chk
      $error("sbus_byte_engine: DIV must be at least 2");
   end
   if (W < 2) begin : g_w_chk
      $error("sbus_byte_engine: W must be at least 2");
   end

   logic             busy;
   sbe_op_e          cur_op;
   logic [CNT_W-1:0] slots_left;
   logic [W-1:0]     shreg;
   logic             cs_q, oe_q, dout_q, done_q;
   logic [W-1:0]     rx_q, crcout_q, residue;
   logic             rise_tick, slot_end, last_slot;
   logic             accept, crc_clr, crc_upd;

   assign accept    = cmd_valid && !busy;
   assign last_slot = slot_end && (slots_left == CNT_W'(1));
   assign crc_clr   = accept && (cmd_op == OP_CRC_CLR);
   assign crc_upd   = busy && last_slot && (cur_op == OP_RECV);

   sbe_clkdiv #(.DIV(DIV)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .sck       (sck),
      .rise_tick (rise_tick),
      .slot_end  (slot_end)
   );

   sbe_rx_crc #(.W(W), .POLY(CRC_POLY)) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (crc_clr),
      .upd     (crc_upd),
      .din     (shreg),
      .residue (residue)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         cur_op     <= OP_NOP;
         slots_left <= '0;
         shreg      <= '0;
         cs_q       <= 1'b1;
         oe_q       <= 1'b0;
         dout_q     <= 1'b0;
         done_q     <= 1'b0;
         rx_q       <= '0;
         crcout_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            case (cmd_op)
               OP_SEL_ON: begin
                  cs_q   <= 1'b0;
                  done_q <= 1'b1;
               end
               OP_SEL_OFF: begin
                  cs_q   <= 1'b1;
                  oe_q   <= 1'b0;
                  dout_q <= 1'b0;
                  done_q <= 1'b1;
               end
               OP_CRC_RD: begin
                  crcout_q <= residue;
                  done_q   <= 1'b1;
               end
               OP_SEND: begin
                  busy       <= 1'b1;
                  cur_op     <= OP_SEND;
                  slots_left <= CNT_W'(W);
                  shreg      <= cmd_arg;
                  oe_q       <= 1'b1;
                  dout_q     <= cmd_arg[W-1];
               end
               OP_TURN: begin
                  oe_q   <= 1'b0;
                  dout_q <= 1'b0;
                  if (cmd_arg == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     busy       <= 1'b1;
                     cur_op     <= OP_TURN;
                     slots_left <= cmd_arg;
                  end
               end
               OP_RECV: begin
                  busy       <= 1'b1;
                  cur_op     <= OP_RECV;
                  slots_left <= CNT_W'(W);
                  shreg      <= '0;
                  oe_q       <= 1'b0;
                  dout_q     <= 1'b0;
               end
               default: done_q <= 1'b1;
            endcase
         end else if (busy) begin
            if (rise_tick && cur_op == OP_RECV) begin
               shreg <= {shreg[W-2:0], io_in};
            end
            if (last_slot) begin
               busy   <= 1'b0;
               done_q <= 1'b1;
               if (cur_op == OP_RECV) begin
                  rx_q <= shreg;
               end
            end else if (slot_end) begin
               slots_left <= slots_left - 1'b1;
               if (cur_op == OP_SEND) begin
                  shreg  <= shreg << 1;
                  dout_q <= shreg[W-2];
               end
            end
         end
      end
   end

   assign cmd_ready = !busy;
   assign done      = done_q;
   assign rx_data   = rx_q;
   assign crc_out   = crcout_q;
   assign cs_n      = cs_q;
   assign io_out    = dout_q;
   assign io_oe     = oe_q;
endmodule

// File: rtl/sbe_checker.sv
module sbe_checker #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cmd_valid,
   input logic         cmd_ready,
   input logic [2:0]   cmd_op,
   input logic         send_msb,
   input logic         done,
   input logic [W-1:0] crc_out,
   input logic         cs_n,
   input logic         sck,
   input logic         io_out,
   input logic         io_oe
);
   logic acc;
   assign acc = cmd_valid && cmd_ready;

   p_idle_sck_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !sck);

   p_done_when_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cmd_ready);

   p_busy_after_send_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 3'd1) |=> !cmd_ready);

   p_send_first_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 3'd1) |=> (io_oe && io_out == $past(send_msb)));

   p_turn_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 3'd2) |=> !io_oe);

   p_recv_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 3'd3) |=> !io_oe);

   p_sel_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 3'd0) |=> !cs_n);

   p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> $stable(cs_n));

   p_clear_then_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 3'd4) ##1 (acc && cmd_op == 3'd5) |=> (crc_out == '0));
endmodule

bind sbus_byte_engine sbe_checker #(.W(W)) u_sbe_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_op    (cmd_op),
   .send_msb  (cmd_arg[W-1]),
   .done      (done),
   .crc_out   (crc_out),
   .cs_n      (cs_n),
   .sck       (sck),
   .io_out    (io_out),
   .io_oe     (io_oe)
);

// File: tb/tb_sbus_byte_engine.sv
module tb_sbus_byte_engine;
   localparam int DIV   = 5;
   localparam int LOW_T = DIV - DIV / 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_ready;
   logic [2:0] cmd_op = 3'd7;
   logic [7:0] cmd_arg = 8'h00;
   logic       done;
   logic [7:0] rx_data, crc_out;
   logic       cs_n, sck, io_out, io_oe;
   logic       io_in = 1'b0;

   int  checks = 0;
   int  fails = 0;
   bit  finished = 1'b0;
   bit  exp_cs = 1'b1;
   bit  exp_oe = 1'b0;
   bit  exp_out = 1'b0;
   logic [7:0] model_crc = 8'h00;

   always #2 clk = ~clk;

   sbus_byte_engine dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_arg(cmd_arg), .done(done), .rx_data(rx_data),
      .crc_out(crc_out), .cs_n(cs_n), .sck(sck), .io_out(io_out),
      .io_oe(io_oe), .io_in(io_in)
   );

   function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
      logic [7:0] r = c;
      for (int i = 7; i >= 0; i--) begin
         logic fb = r[7] ^ d[i];
         r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Issue one command and compare the pins with the model on every cycle
   // up to and including the done cycle; returns at the done-cycle negedge.
   task automatic run(input logic [2:0] op, input logic [7:0] arg,
                      input logic [7:0] resp, input string req);
      int nslots = (op == 3'd1 || op == 3'd3) ? 8 : (op == 3'd2) ? int'(arg) : 0;
      int dur = nslots * DIV;
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_arg   = arg;
      case (op)
         3'd0: exp_cs = 1'b0;
         3'd6: begin exp_cs = 1'b1; exp_oe = 1'b0; exp_out = 1'b0; end
         3'd1: exp_oe = 1'b1;
         3'd2, 3'd3: begin exp_oe = 1'b0; exp_out = 1'b0; end
         default: ;
      endcase
      @(posedge clk);
      for (int t = 0; t <= dur; t++) begin
         int  slot = t / DIV;
         int  ph   = t % DIV;
         logic e_sck = (t < dur) && (ph >= LOW_T);
         @(negedge clk);
         if (t == 0) cmd_valid = 1'b0;
         if (op == 3'd1) exp_out = arg[7 - ((slot > 7) ? 7 : slot)];
         if (op == 3'd3 && t < dur && ph == 0) io_in = resp[7 - slot];
         check(req, {26'd0, sck, done, cmd_ready, io_oe, io_out, cs_n},
                    {26'd0, e_sck, (t == dur), (t >= dur), exp_oe, exp_out, exp_cs});
      end
      if (op == 3'd3) begin
         model_crc = ref_crc(model_crc, resp);
         check("R6 rx_data", {24'd0, rx_data}, {24'd0, resp});
      end
      if (op == 3'd4) model_crc = 8'h00;
      if (op == 3'd5) check(req, {24'd0, crc_out}, {24'd0, model_crc});
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 pins", {26'd0, sck, done, cmd_ready, io_oe, io_out, cs_n},
                       {26'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1});
      check("R1 crc_out", {24'd0, crc_out}, 32'd0);
      run(3'd5, 8'h00, 8'h00, "R1 R9 crc read after reset");
      // frame 1: legal turnaround, good packet
      run(3'd0, 8'h00, 8'h00, "R2 select on");
      run(3'd1, 8'h44, 8'h00, "R3 R4 send");
      run(3'd1, 8'h00, 8'h00, "R4 send zero");
      run(3'd1, 8'h64, 8'h00, "R4 send");
      run(3'd1, 8'h16, 8'h00, "R4 send crc byte verbatim");
      run(3'd5, 8'h00, 8'h00, "R8 crc untouched by send");
      run(3'd2, 8'd2, 8'h00, "R5 turnaround 2");
      run(3'd5, 8'h00, 8'h00, "R8 crc untouched by turnaround");
      run(3'd3, 8'h00, 8'h0F, "R6 recv wait code");
      run(3'd5, 8'h00, 8'h00, "R7 R9 crc after one byte");
      run(3'd4, 8'h00, 8'h00, "R8 crc clear");
      run(3'd5, 8'h00, 8'h00, "R8 crc zero after clear");
      run(3'd3, 8'h00, 8'h5A, "R6 recv");
      run(3'd3, 8'h00, 8'hA5, "R6 recv");
      run(3'd3, 8'h00, 8'h00, "R6 recv");
      run(3'd3, 8'h00, model_crc, "R6 R7 recv trailing crc");
      run(3'd5, 8'h00, 8'h00, "R7 R9 residue zero read in done cycle");
      check("R7 residue", {24'd0, crc_out}, 32'd0);
      run(3'd6, 8'h00, 8'h00, "R2 select off");
      // frame 2: injected short and long turnarounds, corrupt packet
      run(3'd0, 8'h00, 8'h00, "R2 select on");
      run(3'd1, 8'h21, 8'h00, "R4 send");
      run(3'd2, 8'd1, 8'h00, "R5 short turnaround");
      run(3'd4, 8'h00, 8'h00, "R8 crc clear");
      run(3'd3, 8'h00, 8'h3C, "R6 recv");
      run(3'd3, 8'h00, 8'h77, "R6 recv bad check byte");
      run(3'd5, 8'h00, 8'h00, "R7 R9 nonzero residue");
      check("R7 residue nonzero", {31'd0, crc_out != 8'h00}, 32'd1);
      run(3'd2, 8'd3, 8'h00, "R5 long turnaround");
      run(3'd3, 8'h00, 8'hFF, "R6 recv all ones");
      run(3'd2, 8'd0, 8'h00, "R5 zero turnaround");
      run(3'd7, 8'h00, 8'h00, "R10 no-op");
      run(3'd1, 8'h81, 8'h00, "R4 send after receive");
      run(3'd6, 8'h00, 8'h00, "R2 select off right after send");
      run(3'd5, 8'h00, 8'h00, "R9 read");
      repeat (2) @(negedge clk);
      check("R10 idle", {30'd0, done, cmd_ready}, {30'd0, 1'b0, 1'b1});
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog R10 actual=hung expected=complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule